// File: doc/BRIEF.md
# Descriptor Accelerator Control and Status Registers

This block is the software-facing register file and interrupt source of a crypto accelerator that walks descriptor chains in memory. Software programs a control word, selects an operating mode through the command register, and writes the address of the first descriptor to kick off a job. The block hands that address to the descriptor engine with a one-cycle start strobe and tracks the job in a small state machine. The engine reports completion, a recoverable error or a hard fault. The resulting state, the error details and the descriptor addresses can then be read back.

A level interrupt is raised while interrupts are enabled and the job has either completed or failed. Software acknowledges it through clear bits in the command register, which take the state back to idle. A descriptor address written while a job is still outstanding is held as pending and launches as soon as the outstanding job is acknowledged. A reset command aborts the engine and returns every register except the version word to its reset value.

Job states, as reported in status bits 2:0, are IDLE (0), BUSY (1), ERR (2), FAULT (3) and DONE (4). The transitions are as follows:
- Start: IDLE to BUSY on a descriptor write.
- Finish: BUSY to DONE on engine done.
- Fail: BUSY to ERR on engine error.
- Crash: BUSY to FAULT on engine fault.
- Acknowledge: DONE or ERR to IDLE, or to BUSY when an address is pending.
- Abort: any state to IDLE on a reset command.

Top module: `desc_ctrl_regs`

## Requirements
- R1: After reset, offset 0x00 reads 3 and every other register (0x04 to 0x20) reads 0; writes to offset 0x00 leave it at 3; irq, eng_start and eng_abort are low.
- R2: The control word at 0x08 keeps only bits 31:24 (throttle), 23:16 (burst), 7 (reseed) and 4 (interrupt enable); all other bits read 0 (mask 0xFFFF0090).
- R3: A write to 0x04 in IDLE raises eng_start for exactly the next cycle with eng_start_addr equal to the written value; 0x20 reads that value; status reads state 1 with bit 11 (unit active) set and bits 31:24 holding the state.
- R4: Engine done in BUSY sets state 4; 0x1C reads eng_cur_addr sampled at that edge.
- R5: Engine error in BUSY sets state 2 and status bit 4; 0x14 captures eng_err_word masked to its fields (mask 0x3FFFE70F) and 0x18 captures eng_fault_addr.
- R6: irq is high exactly when control bit 4 is set and the state is 2 or 4; clearing bit 4 drops irq without changing the state.
- R7: Command bit 8 alone leaves DONE. ERR is left only when bits 8 and 9 are written together. Bit 9 alone zeros 0x14 and leaves the state unchanged.
- R8: A write to 0x04 in BUSY, DONE or ERR is held pending and sets status bit 3. When the job is acknowledged, the pending address is started (eng_start, 0x20 updated) instead of returning to IDLE.
- R9: Engine fault in BUSY sets state 3 with irq low and captures 0x18; FAULT ignores descriptor writes and clear commands.
- R10: Command bit 0 pulses eng_abort for one cycle. It returns state, control, error, fault, descriptor addresses and the pending request to reset values, while the version word stays 3.
- R11: Command bit 16 sets batch mode (status bit 16) and bit 18 sets debug mode (status bit 18, batch cleared; debug wins if both). The mode bits take effect after a reset command in the same write, and the command register reads 0.
- R12: Engine done, error and fault pulses outside BUSY change no register and raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; data valid the next cycle |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| eng_done | input | 1 | Engine finished the chain |
| eng_err | input | 1 | Engine stopped on an error |
| eng_fault | input | 1 | Engine hit an unrecoverable fault |
| eng_err_word | input | 32 | Error details presented with eng_err |
| eng_fault_addr | input | 32 | Address involved in the error or fault |
| eng_cur_addr | input | 32 | Descriptor address the engine was working on |
| eng_start | output | 1 | One-cycle start strobe to the engine |
| eng_start_addr | output | 32 | First descriptor address for the engine |
| eng_abort | output | 1 | One-cycle abort strobe to the engine |
| irq | output | 1 | Level interrupt |

## Verification
Every register write and engine event takes effect at the clock edge that samples it. State, status, irq and eng_start therefore change at that edge, and the bench checks them at the falling edge right after. A read returns its data at the edge that samples the read strobe. The monitor pops the expected word at the falling edge that follows, so a value is always compared one edge after the read was issued. The bench also checks that eng_start has dropped at the falling edge after that, and it tests a pending start only after the acknowledging write.

// File: rtl/desc_ctrl_pkg.sv
package desc_ctrl_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_BUSY  = 3'd1,
        ST_ERR   = 3'd2,
        ST_FAULT = 3'd3,
        ST_DONE  = 3'd4
    } job_state_e;

    // register byte offsets
    localparam logic [7:0] OFS_VERSION = 8'h00;
    localparam logic [7:0] OFS_DESC    = 8'h04;
    localparam logic [7:0] OFS_CTRL    = 8'h08;
    localparam logic [7:0] OFS_CMD     = 8'h0C;
    localparam logic [7:0] OFS_STATUS  = 8'h10;
    localparam logic [7:0] OFS_ERRSTAT = 8'h14;
    localparam logic [7:0] OFS_FADDR   = 8'h18;
    localparam logic [7:0] OFS_CURDESC = 8'h1C;
    localparam logic [7:0] OFS_INIDESC = 8'h20;

    // writable control bits: throttle, burst, reseed, irq enable
    localparam logic [DATA_W-1:0] CTRL_MASK = 32'hFFFF_0090;
    localparam int CTRL_IE_BIT = 4;

    // error status fields: source, dma dir/size/cause, unit detail, unit id
    localparam logic [DATA_W-1:0] ERR_MASK = 32'h3FFF_E70F;

    // command bit positions
    localparam int CMD_RESET_BIT  = 0;
    localparam int CMD_CLRINT_BIT = 8;
    localparam int CMD_CLRERR_BIT = 9;
    localparam int CMD_BATCH_BIT  = 16;
    localparam int CMD_DEBUG_BIT  = 18;

endpackage

// File: rtl/desc_cmd_decode.sv
module desc_cmd_decode
    import desc_ctrl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [4:0]        cmd_bits,   // {debug, batch, clr_err, clr_int, reset}
    output logic              wr_desc,
    output logic              wr_ctrl,
    output logic              cmd_reset,
    output logic              clr_int,
    output logic              clr_err,
    output logic              sel_batch,
    output logic              sel_debug
);

    logic wr_cmd;

    always_comb begin
        wr_desc   = wr_en && (addr == ADDR_W'(OFS_DESC));
        wr_ctrl   = wr_en && (addr == ADDR_W'(OFS_CTRL));
        wr_cmd    = wr_en && (addr == ADDR_W'(OFS_CMD));
        cmd_reset = wr_cmd && cmd_bits[0];
        clr_int   = wr_cmd && cmd_bits[1];
        clr_err   = wr_cmd && cmd_bits[2];
        sel_batch = wr_cmd && cmd_bits[3];
        sel_debug = wr_cmd && cmd_bits[4];
    end

    // R2
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_desc, wr_ctrl, wr_cmd}));

endmodule

// File: rtl/desc_job_fsm.sv
module desc_job_fsm
    import desc_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_desc,
    input  logic [DATA_W-1:0] desc_wdata,
    input  logic              cmd_reset,
    input  logic              clr_int,
    input  logic              clr_err,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_fault,
    output job_state_e        state,
    output logic              desc_full,
    output logic              go,
    output logic [DATA_W-1:0] go_addr,
    output logic              done_ev,
    output logic              err_ev,
    output logic              fault_ev,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_start_addr,
    output logic              eng_abort
);

    job_state_e        state_q, state_d;
    logic              pend_q, pend_d;
    logic [DATA_W-1:0] paddr_q, paddr_d;
    logic              ack;
    logic              outstanding;

    always_comb begin
        state_d  = state_q;
        pend_d   = pend_q;
        paddr_d  = paddr_q;
        go       = 1'b0;
        go_addr  = paddr_q;
        done_ev  = 1'b0;
        err_ev   = 1'b0;
        fault_ev = 1'b0;
        ack      = 1'b0;
        outstanding = (state_q == ST_BUSY) || (state_q == ST_DONE) || (state_q == ST_ERR);
        if (cmd_reset) begin
            state_d = ST_IDLE;
            pend_d  = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wr_desc) begin
                        go      = 1'b1;
                        go_addr = desc_wdata;
                        state_d = ST_BUSY;
                    end
                end
                ST_BUSY: begin
                    if (eng_fault) begin
                        fault_ev = 1'b1;
                        state_d  = ST_FAULT;
                    end else if (eng_err) begin
                        err_ev  = 1'b1;
                        state_d = ST_ERR;
                    end else if (eng_done) begin
                        done_ev = 1'b1;
                        state_d = ST_DONE;
                    end
                end
                ST_DONE:  ack = clr_int;
                ST_ERR:   ack = clr_int && clr_err;
                ST_FAULT: ack = 1'b0;
                default:  state_d = ST_IDLE;
            endcase
            if (wr_desc && outstanding) begin
                pend_d  = 1'b1;
                paddr_d = desc_wdata;
            end
            if (ack) begin
                if (pend_d) begin
                    go      = 1'b1;
                    go_addr = paddr_d;
                    pend_d  = 1'b0;
                    state_d = ST_BUSY;
                end else begin
                    state_d = ST_IDLE;
                end
            end
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            paddr_q <= '0;
        end else begin
            state_q <= state_d;
            pend_q  <= pend_d;
            paddr_q <= paddr_d;
        end
    end

    // engine-side outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start      <= 1'b0;
            eng_start_addr <= '0;
            eng_abort      <= 1'b0;
        end else begin
            eng_start <= go;
            eng_abort <= cmd_reset;
            if (go) begin
                eng_start_addr <= go_addr;
            end else if (cmd_reset) begin
                eng_start_addr <= '0;
            end
        end
    end

    assign state     = state_q;
    assign desc_full = pend_q;

    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> state_q == ST_BUSY);

    // R3
    idle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_desc && state_q == ST_IDLE && !cmd_reset)
        |=> (eng_start && eng_start_addr == $past(desc_wdata)));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT && !cmd_reset) |=> state_q == ST_FAULT);

    // R10
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reset |=> (state_q == ST_IDLE && !pend_q && eng_abort));

endmodule

// File: rtl/desc_reg_bank.sv
module desc_reg_bank
    import desc_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int VERSION_ID = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_desc,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    input  logic              cmd_reset,
    input  logic              clr_err,
    input  logic              sel_batch,
    input  logic              sel_debug,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  job_state_e        state,
    input  logic              desc_full,
    input  logic              go,
    input  logic [DATA_W-1:0] go_addr,
    input  logic              done_ev,
    input  logic              err_ev,
    input  logic              fault_ev,
    input  logic [DATA_W-1:0] eng_err_word,
    input  logic [DATA_W-1:0] eng_fault_addr,
    input  logic [DATA_W-1:0] eng_cur_addr,
    output logic              ctrl_ie,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] ctrl_q, desc_q, errstat_q, faddr_q, cur_q, ini_q;
    logic [1:0]        mode_q, mode_base;   // {debug, batch}
    logic [DATA_W-1:0] status_w, rd_mux;
    logic [2:0]        st_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            desc_q    <= '0;
            errstat_q <= '0;
            faddr_q   <= '0;
            cur_q     <= '0;
            ini_q     <= '0;
        end else if (cmd_reset) begin
            ctrl_q    <= '0;
            desc_q    <= '0;
            errstat_q <= '0;
            faddr_q   <= '0;
            cur_q     <= '0;
            ini_q     <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata & CTRL_MASK;
            if (wr_desc) desc_q <= wdata;
            if (err_ev) begin
                errstat_q <= eng_err_word & ERR_MASK;
            end else if (clr_err) begin
                errstat_q <= '0;
            end
            if (err_ev || fault_ev) faddr_q <= eng_fault_addr;
            if (go) begin
                cur_q <= go_addr;
                ini_q <= go_addr;
            end else if (done_ev || err_ev || fault_ev) begin
                cur_q <= eng_cur_addr;
            end
        end
    end

    always_comb begin
        mode_base = cmd_reset ? 2'b00 : mode_q;
        if (sel_debug) begin
            mode_base = 2'b10;
        end else if (sel_batch) begin
            mode_base = 2'b01;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 2'b00;
        else        mode_q <= mode_base;
    end

    always_comb begin
        st_code  = state;
        status_w = '0;
        status_w[2:0]   = st_code;
        status_w[3]     = desc_full;
        status_w[4]     = (state == ST_ERR);
        status_w[11]    = (state == ST_BUSY);
        status_w[16]    = mode_q[0];
        status_w[18]    = mode_q[1];
        status_w[31:24] = {5'b0, st_code};
    end

    always_comb begin
        unique case (rd_addr)
            ADDR_W'(OFS_VERSION): rd_mux = DATA_W'(VERSION_ID);
            ADDR_W'(OFS_DESC):    rd_mux = desc_q;
            ADDR_W'(OFS_CTRL):    rd_mux = ctrl_q;
            ADDR_W'(OFS_STATUS):  rd_mux = status_w;
            ADDR_W'(OFS_ERRSTAT): rd_mux = errstat_q;
            ADDR_W'(OFS_FADDR):   rd_mux = faddr_q;
            ADDR_W'(OFS_CURDESC): rd_mux = cur_q;
            ADDR_W'(OFS_INIDESC): rd_mux = ini_q;
            default:              rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign ctrl_ie = ctrl_q[CTRL_IE_BIT];

    // R5
    err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_ev |=> errstat_q == ($past(eng_err_word) & ERR_MASK));

    // R7
    errstat_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(errstat_q) |-> $past(err_ev || clr_err || cmd_reset));

    // R11
    mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(mode_q));

endmodule

// File: rtl/desc_ctrl_regs.sv
module desc_ctrl_regs
    import desc_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int VERSION_ID = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              eng_done,
    input  logic              eng_err,
    input  logic              eng_fault,
    input  logic [31:0]       eng_err_word,
    input  logic [31:0]       eng_fault_addr,
    input  logic [31:0]       eng_cur_addr,
    output logic              eng_start,
    output logic [31:0]       eng_start_addr,
    output logic              eng_abort,
    output logic              irq
);

    logic              wr_desc, wr_ctrl, cmd_reset, clr_int, clr_err, sel_batch, sel_debug;
    logic [4:0]        cmd_bits;
    job_state_e        state;
    logic              desc_full, go, done_ev, err_ev, fault_ev, ctrl_ie;
    logic [DATA_W-1:0] go_addr;

    assign cmd_bits = {reg_wdata[CMD_DEBUG_BIT], reg_wdata[CMD_BATCH_BIT],
                       reg_wdata[CMD_CLRERR_BIT], reg_wdata[CMD_CLRINT_BIT],
                       reg_wdata[CMD_RESET_BIT]};

    desc_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .cmd_bits  (cmd_bits),
        .wr_desc   (wr_desc),
        .wr_ctrl   (wr_ctrl),
        .cmd_reset (cmd_reset),
        .clr_int   (clr_int),
        .clr_err   (clr_err),
        .sel_batch (sel_batch),
        .sel_debug (sel_debug)
    );

    desc_job_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_desc        (wr_desc),
        .desc_wdata     (reg_wdata),
        .cmd_reset      (cmd_reset),
        .clr_int        (clr_int),
        .clr_err        (clr_err),
        .eng_done       (eng_done),
        .eng_err        (eng_err),
        .eng_fault      (eng_fault),
        .state          (state),
        .desc_full      (desc_full),
        .go             (go),
        .go_addr        (go_addr),
        .done_ev        (done_ev),
        .err_ev         (err_ev),
        .fault_ev       (fault_ev),
        .eng_start      (eng_start),
        .eng_start_addr (eng_start_addr),
        .eng_abort      (eng_abort)
    );

    desc_reg_bank #(.ADDR_W(ADDR_W), .VERSION_ID(VERSION_ID)) u_bank (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_desc        (wr_desc),
        .wr_ctrl        (wr_ctrl),
        .wdata          (reg_wdata),
        .cmd_reset      (cmd_reset),
        .clr_err        (clr_err),
        .sel_batch      (sel_batch),
        .sel_debug      (sel_debug),
        .rd_en          (reg_rd_en),
        .rd_addr        (reg_addr),
        .state          (state),
        .desc_full      (desc_full),
        .go             (go),
        .go_addr        (go_addr),
        .done_ev        (done_ev),
        .err_ev         (err_ev),
        .fault_ev       (fault_ev),
        .eng_err_word   (eng_err_word),
        .eng_fault_addr (eng_fault_addr),
        .eng_cur_addr   (eng_cur_addr),
        .ctrl_ie        (ctrl_ie),
        .rdata          (reg_rdata)
    );

    assign irq = ctrl_ie && ((state == ST_DONE) || (state == ST_ERR));

    // R9
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FAULT) |-> !irq);

    // R4
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_ev && ctrl_ie && !wr_ctrl) |=> irq);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !wr_desc) |=> (state == ST_IDLE && !irq));

endmodule

// File: tb/desc_ctrl_regs_bench.sv
module desc_ctrl_regs_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_done = 1'b0, eng_err = 1'b0, eng_fault = 1'b0;
    logic [31:0] eng_err_word = '0, eng_fault_addr = '0, eng_cur_addr = '0;
    logic        eng_start, eng_abort, irq;
    logic [31:0] eng_start_addr;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    desc_ctrl_regs u_desc_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_done(eng_done), .eng_err(eng_err), .eng_fault(eng_fault),
        .eng_err_word(eng_err_word), .eng_fault_addr(eng_fault_addr),
        .eng_cur_addr(eng_cur_addr), .eng_start(eng_start),
        .eng_start_addr(eng_start_addr), .eng_abort(eng_abort), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // driver: pushes the expected word, the monitor compares it
    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) eng_done = 1'b1;
        else if (which == 1) eng_err = 1'b1;
        else eng_fault = 1'b1;
        @(negedge clk);
        eng_done = 1'b0; eng_err = 1'b0; eng_fault = 1'b0;
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            if (reg_rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL scoreboard: got %08h expected none", reg_rdata);
                end else begin
                    chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 start", {31'b0, eng_start}, 32'h0);
        chk("R1 abort", {31'b0, eng_abort}, 32'h0);
        rd(8'h00, 32'h3, "R1 version");
        for (int i = 1; i <= 8; i++) rd(8'(i * 4), 32'h0, "R1 reset value");
        wr(8'h00, 32'h55);
        rd(8'h00, 32'h3, "R1 version write ignored");
        // R2
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, 32'hFFFF_0090, "R2 ctrl mask");
        wr(8'h08, 32'h0000_0010);
        // R3
        wr(8'h04, 32'h0000_1000);
        chk("R3 start pulse", {31'b0, eng_start}, 32'h1);
        chk("R3 start addr", eng_start_addr, 32'h1000);
        @(negedge clk);
        chk("R3 start drops", {31'b0, eng_start}, 32'h0);
        rd(8'h10, 32'h0100_0801, "R3 status busy");
        rd(8'h20, 32'h1000, "R3 initial desc");
        chk("R3 irq low", {31'b0, irq}, 32'h0);
        // R4
        eng_cur_addr = 32'h1040;
        pulse(0);
        chk("R4 irq", {31'b0, irq}, 32'h1);
        rd(8'h10, 32'h0400_0004, "R4 status done");
        rd(8'h1C, 32'h1040, "R4 current desc");
        // R6
        wr(8'h08, 32'h0);
        chk("R6 irq masked", {31'b0, irq}, 32'h0);
        rd(8'h10, 32'h0400_0004, "R6 state kept");
        wr(8'h08, 32'h10);
        chk("R6 irq back", {31'b0, irq}, 32'h1);
        // R7 done acknowledged by clear-interrupt alone
        wr(8'h0C, 32'h100);
        chk("R7 irq cleared", {31'b0, irq}, 32'h0);
        rd(8'h10, 32'h0, "R7 idle");
        // R12
        pulse(0); pulse(1); pulse(2);
        chk("R12 irq", {31'b0, irq}, 32'h0);
        rd(8'h10, 32'h0, "R12 status idle");
        rd(8'h14, 32'h0, "R12 errstat");
        // R5
        wr(8'h04, 32'h2000);
        eng_err_word = 32'hFFFF_FFFF; eng_fault_addr = 32'hDEAD_0000; eng_cur_addr = 32'h2010;
        pulse(1);
        chk("R5 irq", {31'b0, irq}, 32'h1);
        rd(8'h10, 32'h0200_0012, "R5 status err");
        rd(8'h14, 32'h3FFF_E70F, "R5 errstat");
        rd(8'h18, 32'hDEAD_0000, "R5 fault addr");
        // R7 error exits only with both clears
        wr(8'h0C, 32'h100);
        chk("R7 irq held", {31'b0, irq}, 32'h1);
        rd(8'h10, 32'h0200_0012, "R7 err kept");
        wr(8'h0C, 32'h200);
        rd(8'h14, 32'h0, "R7 errstat zeroed");
        rd(8'h10, 32'h0200_0012, "R7 state after clr_err");
        wr(8'h0C, 32'h300);
        chk("R7 irq dropped", {31'b0, irq}, 32'h0);
        rd(8'h10, 32'h0, "R7 idle after both");
        // R8
        wr(8'h04, 32'h3000);
        wr(8'h04, 32'h3100);
        chk("R8 no start while busy", {31'b0, eng_start}, 32'h0);
        rd(8'h10, 32'h0100_0809, "R8 full busy");
        pulse(0);
        rd(8'h10, 32'h0400_000C, "R8 full done");
        wr(8'h0C, 32'h100);
        chk("R8 pending start", {31'b0, eng_start}, 32'h1);
        chk("R8 pending addr", eng_start_addr, 32'h3100);
        rd(8'h10, 32'h0100_0801, "R8 busy again");
        rd(8'h20, 32'h3100, "R8 initial desc");
        // R9
        eng_fault_addr = 32'hBEEF_0000;
        pulse(2);
        chk("R9 irq low", {31'b0, irq}, 32'h0);
        rd(8'h10, 32'h0300_0003, "R9 fault");
        rd(8'h18, 32'hBEEF_0000, "R9 fault addr");
        wr(8'h04, 32'h4000);
        chk("R9 desc ignored", {31'b0, eng_start}, 32'h0);
        wr(8'h0C, 32'h300);
        rd(8'h10, 32'h0300_0003, "R9 sticky");
        // R10
        wr(8'h0C, 32'h1);
        chk("R10 abort", {31'b0, eng_abort}, 32'h1);
        rd(8'h00, 32'h3, "R10 version");
        for (int i = 1; i <= 8; i++) rd(8'(i * 4), 32'h0, "R10 cleared");
        wr(8'h04, 32'h5000);
        wr(8'h04, 32'h5100);
        wr(8'h0C, 32'h1);
        rd(8'h10, 32'h0, "R10 pending dropped");
        wr(8'h04, 32'h6000);
        chk("R10 fresh start", eng_start_addr, 32'h6000);
        pulse(0);
        chk("R10 ie cleared", {31'b0, irq}, 32'h0);
        wr(8'h0C, 32'h100);
        // R11
        wr(8'h0C, 32'h1_0000);
        rd(8'h10, 32'h0001_0000, "R11 batch");
        wr(8'h0C, 32'h4_0000);
        rd(8'h10, 32'h0004_0000, "R11 debug");
        wr(8'h0C, 32'h5_0000);
        rd(8'h10, 32'h0004_0000, "R11 debug wins");
        rd(8'h0C, 32'h0, "R11 command reads zero");
        wr(8'h08, 32'h10);
        wr(8'h0C, 32'h1_0001);
        rd(8'h10, 32'h0001_0000, "R11 mode after reset");
        rd(8'h08, 32'h0, "R11 ctrl reset");
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule